// File: doc/BRIEF.md
# Multi-rate PCM playback sequencer

This block plays a stored phrase, or a sentence made of several linked phrases, from a byte-wide sample memory. A start request carries a 6-bit phrase code. The block looks the code up in a phrase table that holds an inclusive start and end address, and in a link table that can name a follow-on phrase. It then steps an 18-bit sample address once per sample period and turns each byte into a 10-bit DAC code. Each byte is expanded either as plain offset binary or as a companded sign/segment/mantissa value.

The sample period comes from a divider on the system clock. The system clock is either a fast 4.096 MHz crystal-class source or a slow 256 kHz RC source, and a 3-bit rate code selects one of seven rates from 4.0 to 16.0 kHz. The three fastest rates cannot be reached from the slow source. A request for one of them, or for the unused code 7, plays at 8.0 kHz and raises a configuration-error flag. At the end of playback the output returns to mid-scale and a one-cycle done pulse is given. A write port fills the sample memory and both tables.

Top module: `pcm_phrase_player`

## Requirements
- R1: After reset, dac_code is 512, and busy, done and cfg_err are 0.
- R2: With clk_is_fast=1, rate codes 0..6 (4.0, 5.3, 6.4, 8.0, 10.6, 12.8, 16.0 kHz) give a sample period of U<<FAST_SHIFT cycles, with U = 32, 24, 20, 16, 12, 10, 8. The default shift gives 1024 down to 256 cycles.
- R3: With clk_is_fast=0, rate codes 0..3 give a sample period of U<<SLOW_SHIFT cycles. The default shift gives 64, 48, 40 and 32 cycles.
- R4: A forbidden setting is a rate code of 4..6 while clk_is_fast=0, or rate code 7 on either clock. It plays with the period of rate code 3. cfg_err shows whether the present clk_is_fast/rate_sel pair is forbidden, one cycle after the inputs change.
- R5: clk_is_fast, rate_sel and fmt_nonlin are captured when a start is accepted. Changing them during playback has no effect on that playback.
- R6: A start is accepted only when busy is 0, and busy is 1 from the next cycle. Let S be the clock edge at which the start is sampled and P the sample period. The first sample of the first phrase appears on dac_code after edge S+P+3, and each later sample of a phrase appears P cycles after the one before it.
- R7: With fmt_nonlin=0, a sample byte b gives dac_code = b*4.
- R8: With fmt_nonlin=1, the byte is laid out as bit 7 sign (1 = above mid-scale), bits 6:4 segment s, and bits 3:0 mantissa m. The magnitude is B(s) + (m << (s>>1)), with B = 0, 16, 32, 64, 96, 160, 224, 352 for s = 0..7. dac_code = 512 + magnitude when the sign is 1, and 512 − magnitude when it is 0.
- R9: A phrase plays every byte from its start address to its end address inclusive. A phrase whose start is greater than its end plays no samples.
- R10: A link entry with bit 6 set continues the sentence with the code in bits 5:0. Each phrase lookup costs 2 cycles before its first sample period starts. A sentence holds at most MAX_PHRASES phrases, and this cap also holds for self-links.
- R11: After the last sample period of a sentence, one more period of P cycles passes. Then dac_code returns to 512, done is 1 for exactly one cycle, and busy falls in that same cycle. Done is seen after edge S + Σ(2 + N·P) + P, where N is the sample count of each phrase.
- R12: A start pulse while busy is 1 is ignored.
- R13: The write port stores ld_data as follows. ld_sel=0 writes sample byte ld_data[7:0] at ld_addr. ld_sel=1 writes the phrase entry for code ld_addr[5:0] as {end, start}, with start in the low ADDR_W bits. ld_sel=2 writes the link entry for code ld_addr[5:0] from ld_data[6:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (fast or slow source) |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Write strobe for memory and tables |
| ld_sel | input | 2 | Write target: 0 samples, 1 phrase entry, 2 link entry |
| ld_addr | input | ADDR_W | Sample address or phrase code |
| ld_data | input | 2*ADDR_W | Write data |
| clk_is_fast | input | 1 | 1 = 4.096 MHz source, 0 = 256 kHz source |
| rate_sel | input | 3 | Sampling-rate code 0..6 |
| fmt_nonlin | input | 1 | 1 = companded bytes, 0 = offset binary |
| start | input | 1 | Start request |
| start_code | input | 6 | Phrase code to play |
| busy | output | 1 | Playback in progress |
| done | output | 1 | One-cycle end-of-playback pulse |
| cfg_err | output | 1 | Present rate/clock pair is forbidden |
| dac_code | output | 10 | Code to the DAC, 512 = mid-scale |

## Verification
The bench builds the block with FAST_SHIFT=2, SLOW_SHIFT=1, MEM_AW=9 and MAX_PHRASES=3. The shortened fast periods (128 down to 32 cycles) let all seven rates, both clocks and the fallback path be played in full within the cycle budget. The 512-byte sample array keeps loading short. A sentence cap of three lets a self-linked phrase hit the cap, and lets random link chains run into it.

// File: rtl/pcm_play_pkg.sv
`timescale 1ns/1ps
package pcm_play_pkg;

    localparam int CODE_W = 6;
    localparam int NUM_CODES = 1 << CODE_W;
    localparam int SMP_W = 8;
    localparam int DAC_W = 10;
    localparam logic [DAC_W-1:0] DAC_MID = 10'd512;
    localparam logic [2:0] RATE_FALLBACK = 3'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_LOAD,
        ST_PLAY,
        ST_DRAIN
    } play_state_e;

    // Divide units; the final ratio is the unit shifted by the clock's shift.
    function automatic logic [5:0] rate_units(input logic [2:0] r);
        logic [5:0] u;
        case (r)
            3'd0:    u = 6'd32;
            3'd1:    u = 6'd24;
            3'd2:    u = 6'd20;
            3'd3:    u = 6'd16;
            3'd4:    u = 6'd12;
            3'd5:    u = 6'd10;
            3'd6:    u = 6'd8;
            default: u = 6'd16;
        endcase
        return u;
    endfunction

    function automatic logic rate_forbidden(input logic fast, input logic [2:0] r);
        return (r == 3'd7) || (!fast && (r >= 3'd4));
    endfunction

    function automatic logic [2:0] rate_apply(input logic fast, input logic [2:0] r);
        return rate_forbidden(fast, r) ? RATE_FALLBACK : r;
    endfunction

    // Segment base: sum of the spans of all lower segments, span = 16 << (s>>1).
    function automatic logic [8:0] seg_base(input logic [2:0] seg);
        logic [8:0] acc;
        acc = '0;
        for (int s = 0; s < 7; s++) begin
            if (s < int'(seg)) acc = acc + (9'd16 << (s >> 1));
        end
        return acc;
    endfunction

    function automatic logic [DAC_W-1:0] expand_companded(input logic [SMP_W-1:0] b);
        logic [8:0] mag;
        mag = seg_base(b[6:4]) + (9'(b[3:0]) << b[6:5]);
        return b[7] ? (DAC_MID + 10'(mag)) : (DAC_MID - 10'(mag));
    endfunction

    function automatic logic [DAC_W-1:0] expand_linear(input logic [SMP_W-1:0] b);
        return {b, 2'b00};
    endfunction

endpackage

// File: rtl/pcm_rate_gen.sv
`timescale 1ns/1ps
module pcm_rate_gen
    import pcm_play_pkg::*;
#(
    parameter int FAST_SHIFT = 5,
    parameter int SLOW_SHIFT = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       run,
    input  logic       fast,
    input  logic [2:0] rate,
    output logic       tick
);
    localparam int MAX_SH = (FAST_SHIFT > SLOW_SHIFT) ? FAST_SHIFT : SLOW_SHIFT;
    localparam int CNT_W = 6 + MAX_SH;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_t;

    div_t s_d, s_q;
    logic [CNT_W-1:0] ratio;

    always_comb begin
        ratio = fast ? (CNT_W'(rate_units(rate)) << FAST_SHIFT)
                     : (CNT_W'(rate_units(rate)) << SLOW_SHIFT);
        tick  = run && (s_q.cnt == '0);
        s_d   = s_q;
        if (restart) begin
            s_d.cnt = ratio - 1'b1;
        end else if (run) begin
            s_d.cnt = tick ? (ratio - 1'b1) : (s_q.cnt - 1'b1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Ticks never come back to back: the shortest period is many cycles (R2).
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // The slow clock never divides by less than the 8.0 kHz ratio (R4).
    p_slow_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !fast) |-> (ratio >= (CNT_W'(16) << SLOW_SHIFT)));

endmodule

// File: rtl/pcm_store.sv
`timescale 1ns/1ps
module pcm_store
    import pcm_play_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int MEM_AW = 11
) (
    input  logic                    clk,
    input  logic                    ld_en,
    input  logic [1:0]              ld_sel,
    input  logic [ADDR_W-1:0]       ld_addr,
    input  logic [2*ADDR_W-1:0]     ld_data,
    input  logic [ADDR_W-1:0]       smp_addr,
    output logic [SMP_W-1:0]        smp_q,
    input  logic [CODE_W-1:0]       tbl_code,
    output logic [ADDR_W-1:0]       tbl_start,
    output logic [ADDR_W-1:0]       tbl_end,
    output logic                    tbl_link,
    output logic [CODE_W-1:0]       tbl_next
);
    localparam int MEM_DEPTH = 1 << MEM_AW;

    logic [SMP_W-1:0]    smp_mem  [MEM_DEPTH];
    logic [2*ADDR_W-1:0] span_mem [NUM_CODES];
    logic [CODE_W:0]     link_mem [NUM_CODES];

    logic [2*ADDR_W-1:0] span_q;
    logic [CODE_W:0]     link_q;
    logic                unused_hi;

    assign unused_hi = ^{ld_addr[ADDR_W-1:MEM_AW], smp_addr[ADDR_W-1:MEM_AW]};

    always_ff @(posedge clk) begin
        if (ld_en && (ld_sel == 2'd0)) smp_mem[ld_addr[MEM_AW-1:0]] <= ld_data[SMP_W-1:0];
        if (ld_en && (ld_sel == 2'd1)) span_mem[ld_addr[CODE_W-1:0]] <= ld_data;
        if (ld_en && (ld_sel == 2'd2)) link_mem[ld_addr[CODE_W-1:0]] <= ld_data[CODE_W:0];
        smp_q  <= smp_mem[smp_addr[MEM_AW-1:0]];
        span_q <= span_mem[tbl_code];
        link_q <= link_mem[tbl_code];
    end

    assign tbl_start = span_q[ADDR_W-1:0];
    assign tbl_end   = span_q[2*ADDR_W-1:ADDR_W];
    assign tbl_link  = link_q[CODE_W];
    assign tbl_next  = link_q[CODE_W-1:0];

endmodule

// File: rtl/pcm_expander.sv
`timescale 1ns/1ps
module pcm_expander
    import pcm_play_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             nonlin,
    input  logic [SMP_W-1:0] smp,
    input  logic             park,
    output logic [DAC_W-1:0] dac
);
    typedef struct packed {
        logic [DAC_W-1:0] code;
    } exp_t;

    exp_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (park) begin
            s_d.code = DAC_MID;
        end else if (load) begin
            s_d.code = nonlin ? expand_companded(smp) : expand_linear(smp);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.code <= DAC_MID;
        else        s_q <= s_d;
    end

    assign dac = s_q.code;

    // Plain bytes only ever land on multiples of four (R7).
    p_linear_grid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !park && !nonlin) |=> (dac[1:0] == 2'b00));

endmodule

// File: rtl/pcm_phrase_player.sv
`timescale 1ns/1ps
module pcm_phrase_player
    import pcm_play_pkg::*;
#(
    parameter int ADDR_W      = 18,
    parameter int MEM_AW      = 11,
    parameter int FAST_SHIFT  = 5,
    parameter int SLOW_SHIFT  = 1,
    parameter int MAX_PHRASES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld_en,
    input  logic [1:0]          ld_sel,
    input  logic [ADDR_W-1:0]   ld_addr,
    input  logic [2*ADDR_W-1:0] ld_data,
    input  logic                clk_is_fast,
    input  logic [2:0]          rate_sel,
    input  logic                fmt_nonlin,
    input  logic                start,
    input  logic [5:0]          start_code,
    output logic                busy,
    output logic                done,
    output logic                cfg_err,
    output logic [9:0]          dac_code
);
    localparam int LINK_W = $clog2(MAX_PHRASES + 1);
    localparam logic [LINK_W-1:0] LAST_LINK = LINK_W'(MAX_PHRASES - 1);

    typedef struct packed {
        play_state_e         state;
        logic [CODE_W-1:0]   code;
        logic [LINK_W-1:0]   links;
        logic [ADDR_W-1:0]   addr;
        logic [ADDR_W-1:0]   stop;
        logic                chain;
        logic [CODE_W-1:0]   nxt;
        logic                fast;
        logic [2:0]          rate;
        logic                nonlin;
        logic                pend;
        logic                done;
        logic                cfg_err;
    } ctl_t;

    ctl_t s_d, s_q;

    logic [SMP_W-1:0]  smp_q;
    logic [ADDR_W-1:0] tbl_start;
    logic [ADDR_W-1:0] tbl_end;
    logic              tbl_link;
    logic [CODE_W-1:0] tbl_next;
    logic              tick;
    logic              div_restart;
    logic              div_run;
    logic              park;

    pcm_store #(
        .ADDR_W (ADDR_W),
        .MEM_AW (MEM_AW)
    ) u_store (
        .clk       (clk),
        .ld_en     (ld_en),
        .ld_sel    (ld_sel),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .smp_addr  (s_q.addr),
        .smp_q     (smp_q),
        .tbl_code  (s_q.code),
        .tbl_start (tbl_start),
        .tbl_end   (tbl_end),
        .tbl_link  (tbl_link),
        .tbl_next  (tbl_next)
    );

    pcm_rate_gen #(
        .FAST_SHIFT (FAST_SHIFT),
        .SLOW_SHIFT (SLOW_SHIFT)
    ) u_rate (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (div_restart),
        .run     (div_run),
        .fast    (s_q.fast),
        .rate    (s_q.rate),
        .tick    (tick)
    );

    pcm_expander u_expand (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (s_q.pend),
        .nonlin (s_q.nonlin),
        .smp    (smp_q),
        .park   (park),
        .dac    (dac_code)
    );

    always_comb begin
        s_d         = s_q;
        s_d.done    = 1'b0;
        s_d.pend    = 1'b0;
        s_d.cfg_err = rate_forbidden(clk_is_fast, rate_sel);
        div_restart = 1'b0;
        div_run     = (s_q.state == ST_PLAY) || (s_q.state == ST_DRAIN);
        park        = 1'b0;

        case (s_q.state)
            ST_IDLE: begin
                if (start) begin
                    s_d.code   = start_code;
                    s_d.links  = '0;
                    s_d.fast   = clk_is_fast;
                    s_d.rate   = rate_apply(clk_is_fast, rate_sel);
                    s_d.nonlin = fmt_nonlin;
                    s_d.state  = ST_LOOKUP;
                end
            end
            ST_LOOKUP: begin
                s_d.state = ST_LOAD;
            end
            ST_LOAD: begin
                s_d.addr    = tbl_start;
                s_d.stop    = tbl_end;
                s_d.chain   = tbl_link;
                s_d.nxt     = tbl_next;
                div_restart = 1'b1;
                if (tbl_start > tbl_end) begin
                    if (tbl_link && (s_q.links < LAST_LINK)) begin
                        s_d.code  = tbl_next;
                        s_d.links = s_q.links + 1'b1;
                        s_d.state = ST_LOOKUP;
                    end else begin
                        s_d.state = ST_DRAIN;
                    end
                end else begin
                    s_d.state = ST_PLAY;
                end
            end
            ST_PLAY: begin
                if (tick) begin
                    s_d.pend = 1'b1;
                    s_d.addr = s_q.addr + 1'b1;
                    if (s_q.addr == s_q.stop) begin
                        if (s_q.chain && (s_q.links < LAST_LINK)) begin
                            s_d.code  = s_q.nxt;
                            s_d.links = s_q.links + 1'b1;
                            s_d.state = ST_LOOKUP;
                        end else begin
                            s_d.state = ST_DRAIN;
                        end
                    end
                end
            end
            ST_DRAIN: begin
                if (tick) begin
                    park      = 1'b1;
                    s_d.done  = 1'b1;
                    s_d.state = ST_IDLE;
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy    = (s_q.state != ST_IDLE);
    assign done    = s_q.done;
    assign cfg_err = s_q.cfg_err;

    // The done pulse coincides with the output back at mid-scale (R11).
    p_done_mid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (dac_code == DAC_MID));

    // Busy has already dropped when done is raised (R11).
    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // Captured settings hold for the whole playback (R5).
    p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(s_q.rate) && $stable(s_q.fast) && $stable(s_q.nonlin)));

    // The slow clock never runs a captured rate above 8.0 kHz (R4).
    p_fallback_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !s_q.fast) |-> (s_q.rate <= RATE_FALLBACK));

    // The address stays inside the phrase while samples are read (R9).
    p_addr_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_PLAY) |-> (s_q.addr <= s_q.stop));

    // The sentence never runs past its phrase cap (R10).
    p_link_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (s_q.links <= LAST_LINK));

endmodule

// File: tb/test_pcm_phrase_player.sv
`timescale 1ns/1ps
module test_pcm_phrase_player;

    localparam int AW   = 18;
    localparam int MAW  = 9;
    localparam int FSH  = 2;
    localparam int SSH  = 1;
    localparam int MAXP = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_en = 1'b0;
    logic [1:0]    ld_sel = '0;
    logic [AW-1:0] ld_addr = '0;
    logic [2*AW-1:0] ld_data = '0;
    logic          clk_is_fast = 1'b1;
    logic [2:0]    rate_sel = '0;
    logic          fmt_nonlin = 1'b0;
    logic          start = 1'b0;
    logic [5:0]    start_code = '0;
    logic          busy, done, cfg_err;
    logic [9:0]    dac_code;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    int m_smp [512];
    int m_start [64];
    int m_end [64];
    int m_link [64];
    int m_next [64];

    pcm_phrase_player #(
        .ADDR_W (AW), .MEM_AW (MAW), .FAST_SHIFT (FSH),
        .SLOW_SHIFT (SSH), .MAX_PHRASES (MAXP)
    ) i_pcm_phrase_player (
        .clk (clk), .rst_n (rst_n), .ld_en (ld_en), .ld_sel (ld_sel),
        .ld_addr (ld_addr), .ld_data (ld_data), .clk_is_fast (clk_is_fast),
        .rate_sel (rate_sel), .fmt_nonlin (fmt_nonlin), .start (start),
        .start_code (start_code), .busy (busy), .done (done),
        .cfg_err (cfg_err), .dac_code (dac_code)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic int period(input int fast, input int rate);
        int r = rate;
        int u;
        if (r == 7 || (fast == 0 && r >= 4)) r = 3;
        case (r)
            0: u = 32; 1: u = 24; 2: u = 20; 3: u = 16;
            4: u = 12; 5: u = 10; default: u = 8;
        endcase
        return fast != 0 ? (u << FSH) : (u << SSH);
    endfunction

    function automatic int expand(input int b, input int nl);
        int seg = (b >> 4) & 7;
        int man = b & 15;
        int base;
        int mag;
        if (nl == 0) return b * 4;
        case (seg)
            0: base = 0;   1: base = 16;  2: base = 32;  3: base = 64;
            4: base = 96;  5: base = 160; 6: base = 224; default: base = 352;
        endcase
        mag = base + (man << (seg / 2));
        return ((b & 128) != 0) ? 512 + mag : 512 - mag;
    endfunction

    task automatic wait_to(input int target);
        while (cyc < target) begin
            @(posedge clk);
            #1;
        end
        @(negedge clk);
    endtask

    // R13: write encodings for samples, phrase entries and link entries
    task automatic wr_smp(input int a, input int b);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = 2'd0; ld_addr = AW'(a); ld_data = (2*AW)'(b);
        m_smp[a] = b;
    endtask

    task automatic wr_span(input int code, input int s, input int e);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = 2'd1; ld_addr = AW'(code);
        ld_data = {AW'(e), AW'(s)};
        m_start[code] = s; m_end[code] = e;
    endtask

    task automatic wr_link(input int code, input int lk, input int nx);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = 2'd2; ld_addr = AW'(code);
        ld_data = (2*AW)'((lk << 6) | nx);
        m_link[code] = lk; m_next[code] = nx;
    endtask

    task automatic ld_stop();
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic play(input int code, input int fast, input int rate,
                        input int nl, input int disturb);
        int p = period(fast, rate);
        int e0;
        int t = 0;
        int c = code;
        bit first = 1;
        @(negedge clk);
        clk_is_fast = fast[0]; rate_sel = 3'(rate); fmt_nonlin = nl[0];
        start_code = 6'(code); start = 1'b1;
        @(posedge clk);
        #1;
        e0 = cyc;
        @(negedge clk);
        start = 1'b0;
        chk(int'(busy), 1, "R6 busy after accepted start");
        for (int ph = 0; ph < MAXP; ph++) begin
            int n = (m_end[c] >= m_start[c]) ? (m_end[c] - m_start[c] + 1) : 0;
            for (int k = 0; k < n; k++) begin
                wait_to(e0 + t + 2 + (k + 1) * p + 1 + p / 2);
                chk(int'(dac_code), expand(m_smp[m_start[c] + k], nl),
                    nl != 0 ? "R8 companded sample (R2/R3/R6 timing)"
                            : "R7 linear sample (R2/R3/R6 timing)");
                if (disturb != 0 && first) begin
                    // R5 and R12: new settings and a second start while busy
                    start_code = 6'(code ^ 1); start = 1'b1;
                    rate_sel = 3'((rate + 3) % 8); clk_is_fast = ~clk_is_fast;
                    fmt_nonlin = ~fmt_nonlin;
                    @(negedge clk);
                    start = 1'b0;
                end
                first = 0;
            end
            t += 2 + n * p;
            if (m_link[c] == 0) break;
            c = m_next[c];
        end
        wait_to(e0 + t + p - 1);
        chk(int'(done), 0, "R11 done not early");
        chk(int'(busy), 1, "R11 busy held in last period");
        wait_to(e0 + t + p);
        chk(int'(done), 1, "R11 done pulse (R10 link count)");
        chk(int'(busy), 0, "R11 busy falls with done");
        chk(int'(dac_code), 512, "R11 output parked at mid-scale");
        wait_to(e0 + t + p + 1);
        chk(int'(done), 0, "R11 done one cycle only");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d5e_0c41));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(int'(dac_code), 512, "R1 reset dac");
        chk(int'(busy), 0, "R1 reset busy");
        chk(int'(done), 0, "R1 reset done");
        chk(int'(cfg_err), 0, "R1 reset cfg_err");
        rst_n = 1'b1;

        // R4: cfg_err follows the present clock/rate pair
        @(negedge clk); clk_is_fast = 1'b1; rate_sel = 3'd6;
        @(negedge clk); chk(int'(cfg_err), 0, "R4 fast 16k allowed");
        clk_is_fast = 1'b0; rate_sel = 3'd5;
        @(negedge clk); chk(int'(cfg_err), 1, "R4 slow 12.8k forbidden");
        clk_is_fast = 1'b1; rate_sel = 3'd7;
        @(negedge clk); chk(int'(cfg_err), 1, "R4 code 7 forbidden");
        clk_is_fast = 1'b0; rate_sel = 3'd3;
        @(negedge clk); chk(int'(cfg_err), 0, "R4 slow 8k allowed");

        // R13: load memory and tables
        for (int a = 0; a < 512; a++) wr_smp(a, int'($urandom % 256));
        for (int c = 0; c < 64; c++) begin
            wr_span(c, 1, 0);
            wr_link(c, 0, 0);
        end
        wr_smp(10, 8'h80); wr_smp(11, 8'hFF); wr_smp(12, 8'h00); wr_smp(13, 8'h7F);
        wr_smp(100, 8'h80); wr_smp(101, 8'hFF); wr_smp(102, 8'h7F);
        wr_smp(103, 8'h00); wr_smp(104, 8'h9A); wr_smp(105, 8'h35);
        wr_span(1, 10, 13);
        wr_span(2, 20, 21); wr_link(2, 1, 3);
        wr_span(3, 30, 32);
        wr_span(4, 40, 41); wr_link(4, 1, 4);
        wr_span(5, 50, 49); wr_link(5, 1, 1);
        wr_span(6, 60, 60);
        wr_span(8, 100, 105);
        wr_span(9, 70, 69);
        for (int c = 10; c < 18; c++) begin
            int s = 200 + int'($urandom % 250);
            wr_span(c, s, s + int'($urandom % 5));
            wr_link(c, int'($urandom % 2), 10 + int'($urandom % 8));
        end
        ld_stop();

        play(1, 1, 0, 0, 0);   // R2 slowest fast rate, R7 corner bytes
        play(8, 1, 6, 1, 0);   // R8 companded corners at 16 kHz
        play(1, 0, 2, 0, 0);   // R3 slow clock
        play(1, 0, 5, 1, 0);   // R4 fallback on slow clock
        play(1, 1, 7, 0, 0);   // R4 code 7 fallback on fast clock
        play(2, 1, 4, 0, 0);   // R10 two-phrase sentence
        play(4, 1, 5, 1, 0);   // R10 self link capped
        play(5, 0, 1, 0, 0);   // R9 empty phrase linking on
        play(9, 1, 3, 0, 0);   // R9 empty sentence
        play(6, 0, 0, 1, 0);   // R9 single sample
        play(1, 1, 3, 0, 1);   // R5 and R12 disturbance
        for (int i = 0; i < 8; i++) begin
            play(10 + int'($urandom % 8), int'($urandom % 2),
                 int'($urandom % 8), int'($urandom % 2), 0);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule